// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches a vector of already-synchronized input lines and turns selected conditions on them into interrupt requests. Each line is set up through a byte-wide register bus. A line can watch for a level or for an edge. It can be set to an active-high or active-low sense. In edge mode it can also be set to fire on either edge.

Edge events are held in a sticky status bit until software clears them with a write-one-to-clear access. Level events are not stored: the status bit follows the pin for as long as the active level lasts. An enable register gates the status into a masked view. The OR of the masked bits drives a single registered interrupt output. A handler reads the masked status, clears the bits it serviced, and uses the enable register to silence lines.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every readable register returns 0 and `irq_o` is 0.
- R2: The line-mode register at 0x404, the any-edge register at 0x408, the polarity register at 0x40C and the enable register at 0x410 each store a bus write. Each one reads back the value written, bit i belonging to line i.
- R3: When line i has its line-mode bit set to 1 (level mode), raw status bit i at 0x414 equals the pin when its polarity bit is 1, and the inverted pin when it is 0. It follows the pin in the same cycle, and a clear write cannot remove it while the level persists.
- R4: When line i has its line-mode bit at 0 (edge mode) and its any-edge bit at 0, a change of the pin against the previous cycle's sample sets sticky raw status bit i. With polarity 1 this is a 0-to-1 change; with polarity 0 it is a 1-to-0 change. The status is readable from the cycle after the pin change, and the opposite edge leaves it unchanged.
- R5: With the line-mode bit at 0 and the any-edge bit at 1, both a rising and a falling change set the sticky status, whatever the polarity bit holds.
- R6: A write to 0x41C clears the sticky edge status of every line whose data bit is 1. Lines written with 0 keep their status, and 0x41C reads as 0.
- R7: When a clear for line i and a new qualifying edge on line i occur in the same cycle, the status bit of line i ends set.
- R8: The masked status at 0x418 equals the raw status ANDed with the enable register; an enable of 0 gives a masked status of 0.
- R9: `irq_o` is registered: in each cycle it equals the OR of the masked status bits of the previous cycle.
- R10: Writes to 0x414 and 0x418 change no register and no status; unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Synchronized input lines |
| bus_wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
Directed patterns test each detection mode against the event it must reject. A rising change on a falling-polarity line, a held level after a clear, and a clear colliding with a fresh edge each separate sticky edge logic from a stuck or wrongly ordered one. Level lines are driven high and low while clear writes are issued, which tells a combinational level status apart from a latched one. A long random run then toggles pins, rewrites all four configuration registers and clears bits at random. Every cycle, raw status, masked status and `irq_o` are compared against a reference model, which exposes any wrong mode combination or off-by-one-cycle timing.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_MODE  = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_ANY   = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_POL   = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_EN    = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;

  // qualifying edge for one line given current and previous sample
  function automatic logic edge_qualifies(input logic cur, input logic prev,
                                          input logic any, input logic pol);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (any) return rise | fall;
    return pol ? rise : fall;
  endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] wdata,
  input  logic [N_LINES-1:0] raw_i,
  input  logic [N_LINES-1:0] masked_i,
  output logic [N_LINES-1:0] rdata_o,
  output logic [N_LINES-1:0] mode_o,
  output logic [N_LINES-1:0] any_o,
  output logic [N_LINES-1:0] pol_o,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] clr_o
);
  logic [N_LINES-1:0] mode_q, mode_d;
  logic [N_LINES-1:0] any_q,  any_d;
  logic [N_LINES-1:0] pol_q,  pol_d;
  logic [N_LINES-1:0] en_q,   en_d;

  always_comb begin
    mode_d = mode_q;
    any_d  = any_q;
    pol_d  = pol_q;
    en_d   = en_q;
    if (wr_en) begin
      unique case (addr)
        OFS_MODE: mode_d = wdata;
        OFS_ANY:  any_d  = wdata;
        OFS_POL:  pol_d  = wdata;
        OFS_EN:   en_d   = wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      any_q  <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else begin
      mode_q <= mode_d;
      any_q  <= any_d;
      pol_q  <= pol_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_MODE: rdata_o = mode_q;
      OFS_ANY:  rdata_o = any_q;
      OFS_POL:  rdata_o = pol_q;
      OFS_EN:   rdata_o = en_q;
      OFS_RAW:  rdata_o = raw_i;
      OFS_MASK: rdata_o = masked_i;
      default:  rdata_o = '0;
    endcase
  end

  assign clr_o  = (wr_en && addr == OFS_CLR) ? wdata : '0;
  assign mode_o = mode_q;
  assign any_o  = any_q;
  assign pol_o  = pol_q;
  assign en_o   = en_q;

  // R10: status offsets are read-only
  assert_status_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFS_RAW || addr == OFS_MASK))
      |=> ($stable(mode_q) && $stable(any_q) && $stable(pol_q) && $stable(en_q)));
endmodule

// File: rtl/gpio_irq_cell.sv
`timescale 1ns/1ps
module gpio_irq_cell
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic mode_i,
  input  logic any_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_o
);
  logic pin_q;
  logic sts_q, sts_d;
  logic hit;

  always_comb begin
    hit   = ~mode_i & edge_qualifies(pin_i, pin_q, any_i, pol_i);
    // a fresh edge overrides a simultaneous clear
    sts_d = (sts_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      sts_q <= sts_d;
    end
  end

  assign raw_o = mode_i ? ~(pin_i ^ pol_i) : sts_q;

  // R4: a latched edge stays until cleared
  assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !clr_i) |=> sts_q);
  // R6: clear with no pin change empties the status
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && pin_i == pin_q) |=> !sts_q);
  // R7: edge wins over a same-cycle clear
  assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !mode_i && any_i && pin_i != pin_q) |=> sts_q);
endmodule

// File: rtl/gpio_irq_merge.sv
`timescale 1ns/1ps
module gpio_irq_merge #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] masked_i,
  output logic               irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |masked_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R9: request follows masked status one cycle later
  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_i != '0) |=> irq_o);
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_i == '0) |=> !irq_o);
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_i,
  input  logic               bus_wr_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  output logic               irq_o
);
  logic [N_LINES-1:0] mode, any, pol, en, clr;
  logic [N_LINES-1:0] raw, masked;

  gpio_irq_regs #(.N_LINES(N_LINES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .raw_i    (raw),
    .masked_i (masked),
    .rdata_o  (bus_rdata),
    .mode_o   (mode),
    .any_o    (any),
    .pol_o    (pol),
    .en_o     (en),
    .clr_o    (clr)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    gpio_irq_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i[i]),
      .mode_i (mode[i]),
      .any_i  (any[i]),
      .pol_i  (pol[i]),
      .clr_i  (clr[i]),
      .raw_o  (raw[i])
    );
  end

  assign masked = raw & en;

  gpio_irq_merge #(.N_LINES(N_LINES)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .masked_i (masked),
    .irq_o    (irq_o)
  );

  // R3: a level line cannot be cleared while its level is active
  assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && clr[0] && pin_i[0] == pol[0] && $stable(pin_i[0]))
      |=> (raw[0] || !mode[0] || pin_i[0] != pol[0]));
endmodule

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
  localparam logic [11:0] A_MODE = 12'h404, A_ANY = 12'h408, A_POL = 12'h40C,
                          A_EN = 12'h410, A_RAW = 12'h414, A_MASK = 12'h418,
                          A_CLR = 12'h41C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pin_i;
  logic        bus_wr_en;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq_o;

  always #2 clk = ~clk;

  gpio_irq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_mode = '0, m_any = '0, m_pol = '0, m_en = '0, m_sts = '0, m_pq = '0;
  logic       m_irq = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_raw(input logic [7:0] p);
    for (int i = 0; i < 8; i++)
      f_raw[i] = m_mode[i] ? (p[i] == m_pol[i]) : m_sts[i];
  endfunction

  function automatic logic [7:0] f_read(input logic [11:0] a, input logic [7:0] p);
    case (a)
      A_MODE: f_read = m_mode;
      A_ANY:  f_read = m_any;
      A_POL:  f_read = m_pol;
      A_EN:   f_read = m_en;
      A_RAW:  f_read = f_raw(p);
      A_MASK: f_read = f_raw(p) & m_en;
      default: f_read = '0;
    endcase
  endfunction

  // one bus cycle: drive, compare against model, advance model at the edge
  task automatic step(input logic [7:0] p, input bit we, input logic [11:0] a,
                      input logic [7:0] d, input string tag, output logic [7:0] got);
    logic [7:0] clr, hit, nsts, nmode, nany, npol, nen;
    logic nirq;
    @(negedge clk);
    pin_i = p; bus_wr_en = we; bus_addr = a; bus_wdata = d;
    #1;
    check(bus_rdata == f_read(a, p), {tag, " read"}, bus_rdata, f_read(a, p));
    check(irq_o == m_irq, {tag, " irq"}, irq_o, m_irq);
    got = bus_rdata;
    clr = (we && a == A_CLR) ? d : 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic r, f;
      r = p[i] & ~m_pq[i];
      f = ~p[i] & m_pq[i];
      hit[i] = ~m_mode[i] & (m_any[i] ? (r | f) : (m_pol[i] ? r : f));
    end
    nsts = (m_sts & ~clr) | hit;
    nirq = |(f_raw(p) & m_en);
    nmode = (we && a == A_MODE) ? d : m_mode;
    nany  = (we && a == A_ANY)  ? d : m_any;
    npol  = (we && a == A_POL)  ? d : m_pol;
    nen   = (we && a == A_EN)   ? d : m_en;
    @(posedge clk);
    m_sts = nsts; m_pq = p; m_irq = nirq;
    m_mode = nmode; m_any = nany; m_pol = npol; m_en = nen;
  endtask

  task automatic wr(input logic [7:0] p, input logic [11:0] a, input logic [7:0] d,
                    input string tag);
    logic [7:0] g;
    step(p, 1'b1, a, d, tag, g);
  endtask

  task automatic expect_rd(input logic [7:0] p, input logic [11:0] a,
                           input logic [7:0] exp, input string tag);
    logic [7:0] g;
    step(p, 1'b0, a, 8'h00, tag, g);
    check(g == exp, {tag, " fixed"}, g, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] g;
    logic [11:0] alist [8];
    alist = '{A_MODE, A_ANY, A_POL, A_EN, A_RAW, A_MASK, A_CLR, 12'h000};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pin_i = '0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    // R1: reset state visible on the bus
    foreach (alist[k]) begin
      bus_addr = alist[k]; #1;
      check(bus_rdata == 8'h00, "R1 reset read", bus_rdata, 0);
    end
    check(irq_o == 1'b0, "R1 reset irq", irq_o, 0);
    @(negedge clk); rst_n = 1'b1;
    foreach (alist[k]) expect_rd(8'h00, alist[k], 8'h00, "R1");

    // R2: configuration read-back
    wr(8'h00, A_MODE, 8'hA5, "R2"); wr(8'h00, A_ANY, 8'h3C, "R2");
    wr(8'h00, A_POL, 8'h0F, "R2");  wr(8'h00, A_EN, 8'h81, "R2");
    expect_rd(8'h00, A_MODE, 8'hA5, "R2"); expect_rd(8'h00, A_ANY, 8'h3C, "R2");
    expect_rd(8'h00, A_POL, 8'h0F, "R2");  expect_rd(8'h00, A_EN, 8'h81, "R2");
    wr(8'h00, A_MODE, 8'h00, "R2"); wr(8'h00, A_ANY, 8'h00, "R2");
    wr(8'h00, A_POL, 8'h01, "R2");  wr(8'h00, A_EN, 8'hFF, "R2");
    wr(8'h00, A_CLR, 8'hFF, "R2");

    // R4: line0 rising, line1 falling
    step(8'h01, 1'b0, A_RAW, 8'h00, "R4", g);
    expect_rd(8'h01, A_RAW, 8'h01, "R4");
    step(8'h03, 1'b0, A_RAW, 8'h00, "R4", g);
    expect_rd(8'h03, A_RAW, 8'h01, "R4");
    step(8'h01, 1'b0, A_RAW, 8'h00, "R4", g);
    expect_rd(8'h01, A_RAW, 8'h03, "R4");
    check(irq_o == 1'b1, "R9 irq high", irq_o, 1);

    // R6: write-one-to-clear
    wr(8'h01, A_CLR, 8'h01, "R6");
    expect_rd(8'h01, A_RAW, 8'h02, "R6");
    expect_rd(8'h01, A_CLR, 8'h00, "R6");
    wr(8'h01, A_CLR, 8'h00, "R6");
    expect_rd(8'h01, A_RAW, 8'h02, "R6");
    wr(8'h01, A_CLR, 8'h02, "R6");
    expect_rd(8'h01, A_RAW, 8'h00, "R6");
    expect_rd(8'h01, A_RAW, 8'h00, "R9");
    check(irq_o == 1'b0, "R9 irq low", irq_o, 0);

    // R5: any-edge on line2 with falling polarity
    wr(8'h01, A_ANY, 8'h04, "R5");
    step(8'h05, 1'b0, A_RAW, 8'h00, "R5", g);
    expect_rd(8'h05, A_RAW, 8'h04, "R5");
    wr(8'h05, A_CLR, 8'h04, "R5");
    step(8'h01, 1'b0, A_RAW, 8'h00, "R5", g);
    expect_rd(8'h01, A_RAW, 8'h04, "R5");
    wr(8'h01, A_CLR, 8'h04, "R5");

    // R7: clear colliding with a rising edge on line0
    step(8'h00, 1'b0, A_RAW, 8'h00, "R7", g);
    wr(8'h01, A_CLR, 8'h01, "R7");
    expect_rd(8'h01, A_RAW, 8'h01, "R7");
    wr(8'h01, A_CLR, 8'h01, "R7");

    // R3: level mode on line4
    wr(8'h01, A_POL, 8'h11, "R3");
    wr(8'h01, A_MODE, 8'h10, "R3");
    expect_rd(8'h11, A_RAW, 8'h10, "R3");
    wr(8'h11, A_CLR, 8'h10, "R3");
    expect_rd(8'h11, A_RAW, 8'h10, "R3");
    expect_rd(8'h01, A_RAW, 8'h00, "R3");
    wr(8'h01, A_POL, 8'h01, "R3");
    expect_rd(8'h01, A_RAW, 8'h10, "R3");

    // R8: masked view
    wr(8'h01, A_EN, 8'h00, "R8");
    expect_rd(8'h01, A_MASK, 8'h00, "R8");
    expect_rd(8'h01, A_MASK, 8'h00, "R8");
    check(irq_o == 1'b0, "R8 irq disabled", irq_o, 0);
    wr(8'h01, A_EN, 8'h10, "R8");
    expect_rd(8'h01, A_MASK, 8'h10, "R8");

    // R10: writes to status offsets ignored, unmapped reads zero
    wr(8'h01, A_RAW, 8'hFF, "R10");
    wr(8'h01, A_MASK, 8'hFF, "R10");
    expect_rd(8'h01, A_EN, 8'h10, "R10");
    expect_rd(8'h01, A_MODE, 8'h10, "R10");
    expect_rd(8'h01, A_RAW, 8'h10, "R10");
    expect_rd(8'h01, 12'h400, 8'h00, "R10");

    // random run across all modes
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] p;
      logic [11:0] a;
      bit we;
      p  = ($urandom % 3 == 0) ? 8'($urandom) : pin_i;
      we = ($urandom % 4 == 0);
      a  = alist[$urandom % 8];
      step(p, we, a, 8'($urandom), "RND R3 R4 R5 R6 R8 R9", g);
    end

    finish_run();
  end
endmodule